// File: doc/BRIEF.md
# Quad-SPI Flash Controller Register File

This block is the software-visible control and status front end of a quad-SPI flash controller. A simple 32-bit bus writes and reads a set of word-aligned registers. They hold the controller's clock and chip configuration, the transfer length, the command word, the flash address and the alternate bytes. The field values drive a separate serial sequencer directly. The two low address bits are ignored, so every access is a full word.

The block keeps four sticky event flags. They are set by pulses from the sequencer and cleared by writing ones to a write-only clear register. Two further status bits are live: the busy bit is a copy of the sequencer's busy line, and the threshold bit compares the byte FIFO fill level against a programmable threshold. An abort request set by software stays visible until the sequencer reports that the abort is finished. An accepted write of the command word issues a one-cycle start pulse to the sequencer when the controller is enabled. The data register is a window onto the byte FIFO: a write pushes a byte and a read pops one.

Top module: `qfc_csr`

## Requirements
- R1: After a synchronous reset, every register reads 0 and every configuration output, `cfg_start` and `cfg_abort` are 0.
- R2: Control word (offset 0x00): bit 0 enable, bit 4 sample shift, bit 7 flash select, bits 11:8 FIFO threshold and bits 31:24 clock prescaler are stored on write, read back and drive their `cfg_` outputs. All other bits read 0, except bit 1 (see R6).
- R3: Device word (offset 0x04): bit 0 clock mode, bits 10:8 minimum chip-select-high time and bits 20:16 flash size are stored, read back and drive outputs. All other bits read 0.
- R4: Status (offset 0x08) holds sticky flags: error at bit 0 (set by `eng_error`), complete at bit 1 (`eng_done`), match at bit 3 (`eng_match`) and timeout at bit 4 (`eng_timeout`). A flag set by an event pulse stays set until cleared. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R5: Writing the clear word (offset 0x0C) with a 1 at bit 0, 1, 3 or 4 clears the matching flag in the next cycle. A 0 at those bits, and any other bit, has no effect. The clear word always reads 0.
- R6: Writing the control word with bit 1 = 1 sets the abort request. It then reads as 1 in control bit 1 and drives `cfg_abort`. Writing bit 1 = 0 does not clear it. It clears on the clock edge where `eng_abort_done` is 1, unless a write setting it lands in the same cycle.
- R7: Status bit 5 equals `eng_busy` in the same cycle. Status bit 2 is 1 exactly when `fifo_level` is greater than the threshold field. Status bits 31:6 read 0.
- R8: The length (0x10), address (0x18) and alternate-byte (0x1C) words are 32-bit read/write and drive `cfg_dlen`, `cfg_addr` and `cfg_alt`.
- R9: A write to the command word (0x14) is stored and drives `cfg_ccr` only when `eng_busy` is 0. While `eng_busy` is 1 the write is ignored.
- R10: `cfg_start` is 1 for exactly the one cycle after an accepted command-word write made while the enable bit was 1. No other cause raises it.
- R11: A write to offset 0x20 raises `fifo_wr_en` in the same cycle with `fifo_wdata` = write data bits 7:0. A read of 0x20 raises `fifo_rd_en` in the same cycle and returns `fifo_rdata` in bits 7:0 with the upper bits 0.
- R12: Offsets with no register read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| cfg_enable | output | 1 | Controller enable |
| cfg_abort | output | 1 | Pending abort request |
| cfg_sshift | output | 1 | Sample shift select |
| cfg_flash_sel | output | 1 | Flash 0 or 1 select |
| cfg_fthres | output | 4 | FIFO threshold field |
| cfg_prescaler | output | 8 | Serial clock prescaler |
| cfg_ckmode | output | 1 | Idle clock level mode |
| cfg_csht | output | 3 | Minimum chip-select-high time |
| cfg_fsize | output | 5 | Flash size field |
| cfg_dlen | output | 32 | Byte count minus one |
| cfg_ccr | output | 32 | Command word for the sequencer |
| cfg_addr | output | 32 | Flash address |
| cfg_alt | output | 32 | Alternate bytes |
| cfg_start | output | 1 | One-cycle transfer start pulse |
| eng_busy | input | 1 | Sequencer busy level |
| eng_done | input | 1 | Transfer complete pulse |
| eng_error | input | 1 | Transfer error pulse |
| eng_match | input | 1 | Status match pulse |
| eng_timeout | input | 1 | Timeout pulse |
| eng_abort_done | input | 1 | Abort finished pulse |
| fifo_wr_en | output | 1 | FIFO push strobe |
| fifo_wdata | output | 8 | Byte pushed into the FIFO |
| fifo_rd_en | output | 1 | FIFO pop strobe |
| fifo_rdata | input | 8 | Byte at the FIFO head |
| fifo_level | input | LVL_W | FIFO fill level in bytes |

## Verification
The bench targets the race between a sequencer event and a software clear on the same flag. A design that let the clear win would lose a completion that arrives just as software acknowledges the previous one. It writes 0 to the abort bit while an abort is pending and then checks the release on the done pulse. A plain read/write bit would drop the request early and leave the sequencer half-stopped. It writes the command word while busy is high and with the enable clear. A design that missed either gate would corrupt a transfer in flight or start the sequencer when the controller is off. It also drives FIFO levels on both sides of the threshold, clear words with ones only in unused bit positions, and unmapped offsets, to catch off-by-one comparisons and decode aliasing.

// File: rtl/qfc_csr_pkg.sv
package qfc_csr_pkg;

    localparam int WORD_W = 32;
    localparam int NFLAG  = 4;

    // byte offsets of the register words
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_DCFG = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_FCLR = 'h0C;
    localparam int OFS_DLEN = 'h10;
    localparam int OFS_CCFG = 'h14;
    localparam int OFS_ADDR = 'h18;
    localparam int OFS_ALT  = 'h1C;
    localparam int OFS_DATA = 'h20;

    localparam int CTRL_ABORT_BIT = 1;
    localparam int STAT_THR_BIT   = 2;
    localparam int STAT_BUSY_BIT  = 5;

    typedef struct packed {
        logic [7:0] prescaler;
        logic [3:0] fthres;
        logic       fsel;
        logic       sshift;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] fsize;
        logic [2:0] csht;
        logic       ckmode;
    } dcfg_t;

    // status bit position of sticky flag i (error, complete, match, timeout)
    function automatic int flag_bit(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 3;
            default: return 4;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.prescaler = w[31:24];
        c.fthres    = w[11:8];
        c.fsel      = w[7];
        c.sshift    = w[4];
        c.enable    = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c, input logic abort);
        logic [WORD_W-1:0] w;
        w                 = '0;
        w[31:24]          = c.prescaler;
        w[11:8]           = c.fthres;
        w[7]              = c.fsel;
        w[4]              = c.sshift;
        w[CTRL_ABORT_BIT] = abort;
        w[0]              = c.enable;
        return w;
    endfunction

    function automatic dcfg_t dcfg_from_word(input logic [WORD_W-1:0] w);
        dcfg_t d;
        d.fsize  = w[20:16];
        d.csht   = w[10:8];
        d.ckmode = w[0];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] dcfg_to_word(input dcfg_t d);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[20:16] = d.fsize;
        w[10:8]  = d.csht;
        w[0]     = d.ckmode;
        return w;
    endfunction

endpackage

// File: rtl/qfc_cfg_regs.sv
module qfc_cfg_regs
    import qfc_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_dcfg,
    input  logic [WORD_W-1:0] wdata,
    input  logic              abort_done,
    output ctrl_t             ctrl_q,
    output dcfg_t             dcfg_q,
    output logic              abort_q
);

    logic abort_set;
    assign abort_set = wr_ctrl & wdata[CTRL_ABORT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            dcfg_q  <= '0;
            abort_q <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_from_word(wdata);
            if (wr_dcfg)
                dcfg_q <= dcfg_from_word(wdata);
            // software can only raise the request; the sequencer drops it
            abort_q <= abort_set | (abort_q & ~abort_done);
        end
    end

endmodule

// File: rtl/qfc_flag_bank.sv
module qfc_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_q
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else
                bit_q <= set_ev[g] | (bit_q & ~clr[g]);
        end
        assign flags_q[g] = bit_q;
    end

endmodule

// File: rtl/qfc_xfer_regs.sv
module qfc_xfer_regs
    import qfc_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_dlen,
    input  logic              wr_ccfg,
    input  logic              wr_addr,
    input  logic              wr_alt,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              enable,
    output logic [WORD_W-1:0] dlen_q,
    output logic [WORD_W-1:0] ccfg_q,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] alt_q,
    output logic              start_q
);

    logic ccfg_take;
    assign ccfg_take = wr_ccfg & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            dlen_q  <= '0;
            ccfg_q  <= '0;
            addr_q  <= '0;
            alt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            if (wr_dlen)   dlen_q <= wdata;
            if (ccfg_take) ccfg_q <= wdata;
            if (wr_addr)   addr_q <= wdata;
            if (wr_alt)    alt_q  <= wdata;
            start_q <= ccfg_take & enable;
        end
    end

endmodule

// File: rtl/qfc_csr.sv
module qfc_csr
    import qfc_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cfg_enable,
    output logic              cfg_abort,
    output logic              cfg_sshift,
    output logic              cfg_flash_sel,
    output logic [3:0]        cfg_fthres,
    output logic [7:0]        cfg_prescaler,
    output logic              cfg_ckmode,
    output logic [2:0]        cfg_csht,
    output logic [4:0]        cfg_fsize,
    output logic [31:0]       cfg_dlen,
    output logic [31:0]       cfg_ccr,
    output logic [31:0]       cfg_addr,
    output logic [31:0]       cfg_alt,
    output logic              cfg_start,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_error,
    input  logic              eng_match,
    input  logic              eng_timeout,
    input  logic              eng_abort_done,
    output logic              fifo_wr_en,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_rd_en,
    input  logic [7:0]        fifo_rdata,
    input  logic [LVL_W-1:0]  fifo_level
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IX_CTRL = IDX_W'(OFS_CTRL / 4);
    localparam logic [IDX_W-1:0] IX_DCFG = IDX_W'(OFS_DCFG / 4);
    localparam logic [IDX_W-1:0] IX_STAT = IDX_W'(OFS_STAT / 4);
    localparam logic [IDX_W-1:0] IX_FCLR = IDX_W'(OFS_FCLR / 4);
    localparam logic [IDX_W-1:0] IX_DLEN = IDX_W'(OFS_DLEN / 4);
    localparam logic [IDX_W-1:0] IX_CCFG = IDX_W'(OFS_CCFG / 4);
    localparam logic [IDX_W-1:0] IX_ADDR = IDX_W'(OFS_ADDR / 4);
    localparam logic [IDX_W-1:0] IX_ALT  = IDX_W'(OFS_ALT / 4);
    localparam logic [IDX_W-1:0] IX_DATA = IDX_W'(OFS_DATA / 4);

    logic [IDX_W-1:0] sel;
    assign sel = bus_addr[ADDR_W-1:2];

    ctrl_t             ctrl_q;
    dcfg_t             dcfg_q;
    logic              abort_q;
    logic [NFLAG-1:0]  flags_q;
    logic [NFLAG-1:0]  flag_set;
    logic [NFLAG-1:0]  flag_clr;
    logic [WORD_W-1:0] dlen_q, ccfg_q, addr_q, alt_q;
    logic              start_q;
    logic              thr_hit;
    logic [WORD_W-1:0] stat_word;

    qfc_cfg_regs i_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (bus_wr_en && sel == IX_CTRL),
        .wr_dcfg    (bus_wr_en && sel == IX_DCFG),
        .wdata      (bus_wdata),
        .abort_done (eng_abort_done),
        .ctrl_q     (ctrl_q),
        .dcfg_q     (dcfg_q),
        .abort_q    (abort_q)
    );

    // flag order: error, complete, match, timeout
    assign flag_set = {eng_timeout, eng_match, eng_done, eng_error};

    for (genvar g = 0; g < NFLAG; g++) begin : g_clr
        assign flag_clr[g] = bus_wr_en && sel == IX_FCLR && bus_wdata[flag_bit(g)];
    end

    qfc_flag_bank #(.N(NFLAG)) i_flags (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (flag_set),
        .clr     (flag_clr),
        .flags_q (flags_q)
    );

    qfc_xfer_regs i_xfer (
        .clk     (clk),
        .rst     (rst),
        .wr_dlen (bus_wr_en && sel == IX_DLEN),
        .wr_ccfg (bus_wr_en && sel == IX_CCFG),
        .wr_addr (bus_wr_en && sel == IX_ADDR),
        .wr_alt  (bus_wr_en && sel == IX_ALT),
        .wdata   (bus_wdata),
        .busy    (eng_busy),
        .enable  (ctrl_q.enable),
        .dlen_q  (dlen_q),
        .ccfg_q  (ccfg_q),
        .addr_q  (addr_q),
        .alt_q   (alt_q),
        .start_q (start_q)
    );

    assign thr_hit = 32'(fifo_level) > 32'(ctrl_q.fthres);

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NFLAG; i++)
            stat_word[flag_bit(i)] = flags_q[i];
        stat_word[STAT_THR_BIT]  = thr_hit;
        stat_word[STAT_BUSY_BIT] = eng_busy;
    end

    always_comb begin
        case (sel)
            IX_CTRL: bus_rdata = ctrl_to_word(ctrl_q, abort_q);
            IX_DCFG: bus_rdata = dcfg_to_word(dcfg_q);
            IX_STAT: bus_rdata = stat_word;
            IX_DLEN: bus_rdata = dlen_q;
            IX_CCFG: bus_rdata = ccfg_q;
            IX_ADDR: bus_rdata = addr_q;
            IX_ALT:  bus_rdata = alt_q;
            IX_DATA: bus_rdata = {24'b0, fifo_rdata};
            default: bus_rdata = '0;
        endcase
    end

    assign fifo_wr_en = bus_wr_en && sel == IX_DATA;
    assign fifo_wdata = bus_wdata[7:0];
    assign fifo_rd_en = bus_rd_en && sel == IX_DATA;

    assign cfg_enable    = ctrl_q.enable;
    assign cfg_abort     = abort_q;
    assign cfg_sshift    = ctrl_q.sshift;
    assign cfg_flash_sel = ctrl_q.fsel;
    assign cfg_fthres    = ctrl_q.fthres;
    assign cfg_prescaler = ctrl_q.prescaler;
    assign cfg_ckmode    = dcfg_q.ckmode;
    assign cfg_csht      = dcfg_q.csht;
    assign cfg_fsize     = dcfg_q.fsize;
    assign cfg_dlen      = dlen_q;
    assign cfg_ccr       = ccfg_q;
    assign cfg_addr      = addr_q;
    assign cfg_alt       = alt_q;
    assign cfg_start     = start_q;

endmodule

// File: rtl/qfc_csr_chk.sv
module qfc_csr_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              cfg_enable,
    input logic              cfg_abort,
    input logic              cfg_start,
    input logic [31:0]       cfg_ccr,
    input logic              eng_busy,
    input logic              eng_abort_done,
    input logic [3:0]        flags_q
);

    logic [ADDR_W-3:0] idx;
    assign idx = bus_addr[ADDR_W-1:2];

    // R6: a pending abort survives until the sequencer reports completion
    a_r6_abort_hold: assert property (@(posedge clk) disable iff (rst)
        cfg_abort && !eng_abort_done |=> cfg_abort);

    // R6: completion drops the request when no new request lands with it
    a_r6_abort_release: assert property (@(posedge clk) disable iff (rst)
        cfg_abort && eng_abort_done && !(bus_wr_en && idx == 0 && bus_wdata[1]) |=> !cfg_abort);

    // R9: command word frozen while the sequencer is busy
    a_r9_ccr_locked: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && idx == 5 && eng_busy |=> $stable(cfg_ccr));

    // R10: a start pulse only follows an accepted command write while enabled
    a_r10_start_cause: assert property (@(posedge clk) disable iff (rst)
        cfg_start |-> $past(bus_wr_en && idx == 5 && !eng_busy && cfg_enable));

    // R5: the clear word reads zero
    a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && idx == 3 |-> bus_rdata == 32'h0);

    // R4: the complete flag stays set without a clear
    a_r4_complete_sticky: assert property (@(posedge clk) disable iff (rst)
        flags_q[1] && !(bus_wr_en && idx == 3 && bus_wdata[1]) |=> flags_q[1]);

    // R7: busy status follows the sequencer line
    a_r7_busy_live: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && idx == 2 |-> bus_rdata[5] == eng_busy);

endmodule

bind qfc_csr qfc_csr_chk #(.ADDR_W(ADDR_W)) i_qfc_csr_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr_en      (bus_wr_en),
    .bus_rd_en      (bus_rd_en),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .cfg_enable     (cfg_enable),
    .cfg_abort      (cfg_abort),
    .cfg_start      (cfg_start),
    .cfg_ccr        (cfg_ccr),
    .eng_busy       (eng_busy),
    .eng_abort_done (eng_abort_done),
    .flags_q        (flags_q)
);

// File: tb/test_qfc_csr.sv
module test_qfc_csr;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr_en = 0, bus_rd_en = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        cfg_enable, cfg_abort, cfg_sshift, cfg_flash_sel, cfg_ckmode, cfg_start;
    logic [3:0]  cfg_fthres;
    logic [7:0]  cfg_prescaler;
    logic [2:0]  cfg_csht;
    logic [4:0]  cfg_fsize;
    logic [31:0] cfg_dlen, cfg_ccr, cfg_addr, cfg_alt;
    logic        eng_busy = 0, eng_done = 0, eng_error = 0, eng_match = 0;
    logic        eng_timeout = 0, eng_abort_done = 0;
    logic        fifo_wr_en, fifo_rd_en;
    logic [7:0]  fifo_wdata;
    logic [7:0]  fifo_rdata = 0;
    logic [4:0]  fifo_level = 0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    qfc_csr i_qfc_csr (.*);

    // ---------------- reference model ----------------
    logic       m_en, m_ss, m_fs, m_abort, m_ck, m_start;
    logic [3:0] m_thr;
    logic [7:0] m_pre;
    logic [2:0] m_csht;
    logic [4:0] m_fsz;
    logic [4:0] m_flag;
    logic [31:0] m_dlen, m_ccr, m_addr, m_alt;

    always @(posedge clk) begin
        int ix;
        logic nstart, nabort, ev;
        cyc++;
        ix = int'(bus_addr[7:2]);
        if (rst) begin
            m_en = 0; m_ss = 0; m_fs = 0; m_abort = 0; m_ck = 0; m_start = 0;
            m_thr = 0; m_pre = 0; m_csht = 0; m_fsz = 0; m_flag = 0;
            m_dlen = 0; m_ccr = 0; m_addr = 0; m_alt = 0;
        end else begin
            nstart = bus_wr_en && ix == 5 && !eng_busy && m_en;
            if (bus_wr_en && ix == 0 && bus_wdata[1]) nabort = 1;
            else if (eng_abort_done)                  nabort = 0;
            else                                      nabort = m_abort;
            for (int b = 0; b < 5; b++) begin
                if (b != 2) begin
                    ev = (b == 0) ? eng_error : (b == 1) ? eng_done :
                         (b == 3) ? eng_match : eng_timeout;
                    if (ev) m_flag[b] = 1;
                    else if (bus_wr_en && ix == 3 && bus_wdata[b]) m_flag[b] = 0;
                end
            end
            if (bus_wr_en) begin
                case (ix)
                    0: begin
                        m_en = bus_wdata[0]; m_ss = bus_wdata[4]; m_fs = bus_wdata[7];
                        m_thr = bus_wdata[11:8]; m_pre = bus_wdata[31:24];
                    end
                    1: begin
                        m_ck = bus_wdata[0]; m_csht = bus_wdata[10:8]; m_fsz = bus_wdata[20:16];
                    end
                    4: m_dlen = bus_wdata;
                    5: if (!eng_busy) m_ccr = bus_wdata;
                    6: m_addr = bus_wdata;
                    7: m_alt = bus_wdata;
                    default: ;
                endcase
            end
            m_start = nstart;
            m_abort = nabort;
        end
    end

    function automatic logic [31:0] exp_read(input int ix);
        logic thr;
        thr = 32'(fifo_level) > 32'(m_thr);
        case (ix)
            0: return {m_pre, 12'b0, m_thr, m_fs, 2'b0, m_ss, 2'b0, m_abort, m_en};
            1: return {11'b0, m_fsz, 5'b0, m_csht, 7'b0, m_ck};
            2: return {26'b0, eng_busy, m_flag[4], m_flag[3], thr, m_flag[1], m_flag[0]};
            4: return m_dlen;
            5: return m_ccr;
            6: return m_addr;
            7: return m_alt;
            8: return {24'b0, fifo_rdata};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edges
    always begin
        @(negedge clk);
        #3;
        if (cyc > 0) begin
            chk("R2 cfg_enable",     32'(cfg_enable),    32'(m_en));
            chk("R2 cfg_sshift",     32'(cfg_sshift),    32'(m_ss));
            chk("R2 cfg_flash_sel",  32'(cfg_flash_sel), 32'(m_fs));
            chk("R2 cfg_fthres",     32'(cfg_fthres),    32'(m_thr));
            chk("R2 cfg_prescaler",  32'(cfg_prescaler), 32'(m_pre));
            chk("R3 cfg_ckmode",     32'(cfg_ckmode),    32'(m_ck));
            chk("R3 cfg_csht",       32'(cfg_csht),      32'(m_csht));
            chk("R3 cfg_fsize",      32'(cfg_fsize),     32'(m_fsz));
            chk("R6 cfg_abort",      32'(cfg_abort),     32'(m_abort));
            chk("R8 cfg_dlen",       cfg_dlen,           m_dlen);
            chk("R8 cfg_addr",       cfg_addr,           m_addr);
            chk("R8 cfg_alt",        cfg_alt,            m_alt);
            chk("R9 cfg_ccr",        cfg_ccr,            m_ccr);
            chk("R10 cfg_start",     32'(cfg_start),     32'(m_start));
            chk("R11 fifo_wr_en",    32'(fifo_wr_en),    32'(bus_wr_en && bus_addr[7:2] == 8));
            chk("R11 fifo_wdata",    32'(fifo_wdata),    32'(bus_wdata[7:0]));
            chk("R11 fifo_rd_en",    32'(fifo_rd_en),    32'(bus_rd_en && bus_addr[7:2] == 8));
            chk("R12 bus_rdata",     bus_rdata,          exp_read(int'(bus_addr[7:2])));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic rdc(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd_en = 1; bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd_en = 0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        for (int a = 0; a <= 'h20; a += 4)
            rdc(8'(a), (a == 'h20) ? 32'h0 : 32'h0, "R1 reset value");
        chk("R1 start after reset", 32'(cfg_start), 0);

        // R2 / R6: control word fields and abort set
        wr(8'h00, 32'hFFFF_FFFF);
        rdc(8'h00, 32'hFF00_0F93, "R2 control readback");
        chk("R6 abort output set", 32'(cfg_abort), 1);
        wr(8'h00, 32'h0);
        rdc(8'h00, 32'h0000_0002, "R6 abort survives zero write");
        @(negedge clk); eng_abort_done = 1;
        @(negedge clk); eng_abort_done = 0;
        rdc(8'h00, 32'h0, "R6 abort released by done");

        // R3: device word
        wr(8'h04, 32'hFFFF_FFFF);
        rdc(8'h04, 32'h001F_0701, "R3 device readback");

        // R8: plain words
        wr(8'h10, 32'h0000_01FF);
        wr(8'h18, 32'h00AB_CDEF);
        wr(8'h1C, 32'h5A5A_A5A5);
        rdc(8'h10, 32'h0000_01FF, "R8 length readback");
        rdc(8'h18, 32'h00AB_CDEF, "R8 address readback");
        rdc(8'h1C, 32'h5A5A_A5A5, "R8 alternate readback");

        // R4: sticky flags
        @(negedge clk); eng_done = 1;
        @(negedge clk); eng_done = 0;
        repeat (2) @(negedge clk);
        rdc(8'h08, 32'h0000_0002, "R4 complete sticky");
        @(negedge clk); eng_error = 1; eng_match = 1; eng_timeout = 1;
        @(negedge clk); eng_error = 0; eng_match = 0; eng_timeout = 0;
        rdc(8'h08, 32'h0000_001B, "R4 all flags set");

        // R5: clear word
        wr(8'h0C, 32'hFFFF_FFE4);
        rdc(8'h08, 32'h0000_001B, "R5 zeros in clear bits no effect");
        wr(8'h0C, 32'h0000_0002);
        rdc(8'h08, 32'h0000_0019, "R5 clear complete only");
        @(negedge clk);
        eng_done = 1; bus_wr_en = 1; bus_addr = 8'h0C; bus_wdata = 32'h2;
        @(negedge clk);
        eng_done = 0; bus_wr_en = 0;
        rdc(8'h08, 32'h0000_001B, "R4 event beats clear");
        rdc(8'h0C, 32'h0, "R5 clear word reads zero");
        wr(8'h0C, 32'h0000_001B);
        rdc(8'h08, 32'h0, "R5 clear all flags");

        // R7: live status bits
        wr(8'h00, 32'h0000_0301);
        fifo_level = 5'd3;
        rdc(8'h08, 32'h0, "R7 level equal threshold");
        fifo_level = 5'd4;
        rdc(8'h08, 32'h0000_0004, "R7 level above threshold");
        eng_busy = 1;
        rdc(8'h08, 32'h0000_0024, "R7 busy live");

        // R9 / R10: command word gating and start
        wr(8'h14, 32'hDEAD_BEEF);
        chk("R10 no start while busy", 32'(cfg_start), 0);
        rdc(8'h14, 32'h0, "R9 write ignored while busy");
        eng_busy = 0;
        @(negedge clk);
        bus_wr_en = 1; bus_addr = 8'h14; bus_wdata = 32'h0C00_0103;
        @(negedge clk);
        bus_wr_en = 0;
        #1 chk("R10 start pulse", 32'(cfg_start), 1);
        @(negedge clk);
        #1 chk("R10 start one cycle", 32'(cfg_start), 0);
        rdc(8'h14, 32'h0C00_0103, "R9 accepted command");
        wr(8'h00, 32'h0);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = 8'h14; bus_wdata = 32'h0000_1111;
        @(negedge clk);
        bus_wr_en = 0;
        #1 chk("R10 no start when disabled", 32'(cfg_start), 0);
        rdc(8'h14, 32'h0000_1111, "R9 stored while disabled");

        // R11: data window
        @(negedge clk);
        bus_wr_en = 1; bus_addr = 8'h20; bus_wdata = 32'h0000_01A5;
        #1;
        chk("R11 push strobe", 32'(fifo_wr_en), 1);
        chk("R11 push byte", 32'(fifo_wdata), 32'hA5);
        @(negedge clk);
        bus_wr_en = 0;
        fifo_rdata = 8'h3C;
        @(negedge clk);
        bus_rd_en = 1; bus_addr = 8'h20;
        #1;
        chk("R11 pop strobe", 32'(fifo_rd_en), 1);
        chk("R11 pop data", bus_rdata, 32'h0000_003C);
        @(negedge clk);
        bus_rd_en = 0;

        // R12: unmapped offsets
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rdc(8'h24, 32'h0, "R12 unmapped reads zero");
        rdc(8'h3C, 32'h0, "R12 high unmapped reads zero");
        rdc(8'h10, 32'h0000_01FF, "R12 length untouched");
        rdc(8'h00, 32'h0, "R12 control untouched");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule